// File: doc/BRIEF.md
# Two-Wire Host Command Controller

This block is the register front end of a two-wire bus host. A CPU writes and reads four small registers: control, address, data and status. The block turns those accesses into single-cycle action requests for a separate bit-level bus engine. Each request carries an operation code, a flag that says whether an acknowledge action runs first, and the ACK/NACK choice for that action. The engine answers each request with a one-cycle done pulse.

The acknowledge action is a stored setting that runs in front of every command. When smart mode is on, reading the data register fires the acknowledge action automatically. Writing the data register never fires it. A byte write in write direction is deferred until the CPU supplies the byte through the data register. A flush strobe returns the host to Idle and drops any request that is still in flight. The transfer direction is latched from the last address write. A data write that comes before any address write sets a sticky error flag.

Top module: `twi_host_ctrl`

## Requirements
- R1: After reset, `eng_req` and `flush_o` are 0, the status register (offset 3) reads 0, and the control register (offset 0) reads 0.
- R2: Writing control bit 3 as 1 raises `flush_o` for exactly one cycle. In that cycle no request is issued, a command written in the same access is discarded, and status reads 0 afterwards (no pending request, no wait, direction write, error clear). Writing bit 3 as 0 produces no pulse and leaves the status unchanged.
- R3: Control bit 2 holds the acknowledge setting (0 = ACK, 1 = NACK). It reads back at bit 2, and every request that performs the acknowledge action presents it on `eng_nack`.
- R4: The command field (control bits 1:0) is a strobe and always reads back as 0.
- R5: Command 0 issues no request.
- R6: Command 1 issues `eng_op`=1 (repeated START) with `eng_ack_en`=1.
- R7: Command 2 in read direction issues `eng_op`=2 (byte read) with `eng_ack_en`=1.
- R8: Command 2 in write direction issues nothing and sets status bit 1 (waiting for data). The next data write issues `eng_op`=3 (byte write) with `eng_ack_en`=0, and `eng_byte` holds the written byte.
- R9: Command 3 issues `eng_op`=4 (STOP) with `eng_ack_en`=1.
- R10: A data-register read (offset 2) returns `eng_rx_data`. When `smart_en`=1 and the host is idle, the read issues `eng_op`=5 (acknowledge only) with `eng_ack_en`=1. When `smart_en`=0 it issues nothing.
- R11: A data-register write while idle issues no request.
- R12: When the acknowledge bit and a command are written in the same access, the request uses the newly written acknowledge value.
- R13: A request raises `eng_req` for one cycle and sets status bit 0 (pending) until `eng_done`. Commands written while a request is pending are ignored.
- R14: A data write that comes before any address write since reset or flush sets status bit 3. The bit stays set through later writes until a flush. Status bit 2 is the direction latched from bit 0 of the last address write (1 = read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset: 0 control, 1 address, 2 data, 3 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| smart_en | input | 1 | Automatic acknowledge on data-register reads |
| eng_req | output | 1 | One-cycle action request to the bus engine |
| eng_op | output | 3 | Operation: 1 START again, 2 read, 3 write, 4 STOP, 5 acknowledge only |
| eng_ack_en | output | 1 | Acknowledge action runs before the operation |
| eng_nack | output | 1 | Acknowledge action sends NACK when 1 |
| eng_byte | output | DATA_W | Last byte written to the address or data register |
| eng_rx_data | input | DATA_W | Byte received by the engine |
| eng_done | input | 1 | Engine finished the pending request |
| flush_o | output | 1 | One-cycle flush strobe to the engine |

## Verification
The assertions assume three things about the inputs. `eng_done` arrives only while a request is pending. At most one of the read or write strobes is active in a cycle. A strobe lasts exactly one cycle per access. The stimulus meets these by issuing one access per task. It pulses done only after a request it has itself observed. After a flush it never answers the request that was dropped.

// File: rtl/twi_hc_pkg.sv
package twi_hc_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_RSTART = 3'd1,
        OP_READ   = 3'd2,
        OP_WRITE  = 3'd3,
        OP_STOP   = 3'd4,
        OP_ACK    = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_WAITD = 2'd2
    } st_e;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_ADDR = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    localparam int BIT_FLUSH = 3;
    localparam int BIT_ACK   = 2;

    localparam logic [1:0] CMD_NOP    = 2'd0;
    localparam logic [1:0] CMD_RSTART = 2'd1;
    localparam logic [1:0] CMD_XFER   = 2'd2;
    localparam logic [1:0] CMD_STOP   = 2'd3;

endpackage

// File: rtl/twi_hc_decode.sv
module twi_hc_decode
    import twi_hc_pkg::*;
(
    input  logic       ctrl_wr,
    input  logic       data_rd,
    input  logic [1:0] cmd,
    input  logic       flush_bit,
    input  logic       ack_bit,
    input  logic       smart_en,
    input  logic       ack_q,
    input  logic       dir_q,
    input  logic       idle,
    output logic       flush_hit,
    output logic       req_valid,
    output op_e        req_op,
    output logic       req_nack,
    output logic       enter_wait
);

    logic ack_eff;

    always_comb begin
        flush_hit  = ctrl_wr & flush_bit;
        ack_eff    = ctrl_wr ? ack_bit : ack_q;
        req_valid  = 1'b0;
        req_op     = OP_NONE;
        enter_wait = 1'b0;
        req_nack   = ack_eff;
        if (!flush_hit && idle) begin
            if (ctrl_wr) begin
                case (cmd)
                    CMD_RSTART: begin
                        req_valid = 1'b1;
                        req_op    = OP_RSTART;
                    end
                    CMD_XFER: begin
                        if (dir_q) begin
                            req_valid = 1'b1;
                            req_op    = OP_READ;
                        end else begin
                            enter_wait = 1'b1;
                        end
                    end
                    CMD_STOP: begin
                        req_valid = 1'b1;
                        req_op    = OP_STOP;
                    end
                    default: begin
                        req_valid = 1'b0;
                    end
                endcase
            end else if (data_rd && smart_en) begin
                req_valid = 1'b1;
                req_op    = OP_ACK;
            end
        end
    end

endmodule

// File: rtl/twi_hc_seq.sv
module twi_hc_seq
    import twi_hc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              addr_wr,
    input  logic              data_wr,
    input  logic              ack_bit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              flush_hit,
    input  logic              req_valid,
    input  op_e               req_op,
    input  logic              req_nack,
    input  logic              enter_wait,
    output st_e               st_q,
    output logic              ack_q,
    output logic              dir_q,
    output logic              bad_q,
    output logic [DATA_W-1:0] byte_q,
    output logic              req_q,
    output op_e               op_q,
    output logic              ack_en_q,
    output logic              nack_q,
    output logic              flush_q
);

    typedef struct packed {
        st_e               st;
        logic              ack;
        logic              dir;
        logic              addr_seen;
        logic              bad;
        logic [DATA_W-1:0] tx;
        logic              req;
        op_e               op;
        logic              ack_en;
        logic              nack;
        logic              flush;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: ST_IDLE, ack: 1'b0, dir: 1'b0, addr_seen: 1'b0, bad: 1'b0,
        tx: '0, req: 1'b0, op: OP_NONE, ack_en: 1'b0, nack: 1'b0, flush: 1'b0
    };

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.req   = 1'b0;
        s_d.flush = 1'b0;
        if (ctrl_wr) begin
            s_d.ack = ack_bit;
        end
        if (flush_hit) begin
            s_d.st        = ST_IDLE;
            s_d.dir       = 1'b0;
            s_d.addr_seen = 1'b0;
            s_d.bad       = 1'b0;
            s_d.flush     = 1'b1;
        end else begin
            if (addr_wr) begin
                s_d.dir       = wdata[0];
                s_d.addr_seen = 1'b1;
                s_d.tx        = wdata;
            end
            if (data_wr) begin
                s_d.tx = wdata;
                if (!s_q.addr_seen) begin
                    s_d.bad = 1'b1;
                end
                if (s_q.st == ST_WAITD) begin
                    s_d.req    = 1'b1;
                    s_d.op     = OP_WRITE;
                    s_d.ack_en = 1'b0;
                    s_d.nack   = s_q.ack;
                    s_d.st     = ST_PEND;
                end
            end
            if (done && s_q.st == ST_PEND) begin
                s_d.st = ST_IDLE;
            end
            if (req_valid) begin
                s_d.req    = 1'b1;
                s_d.op     = req_op;
                s_d.ack_en = 1'b1;
                s_d.nack   = req_nack;
                s_d.st     = ST_PEND;
            end
            if (enter_wait) begin
                s_d.st = ST_WAITD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_q     = s_q.st;
    assign ack_q    = s_q.ack;
    assign dir_q    = s_q.dir;
    assign bad_q    = s_q.bad;
    assign byte_q   = s_q.tx;
    assign req_q    = s_q.req;
    assign op_q     = s_q.op;
    assign ack_en_q = s_q.ack_en;
    assign nack_q   = s_q.nack;
    assign flush_q  = s_q.flush;

    // R13: a request is never followed by another in the next cycle
    a_r13_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

    // R13: input assumption, done only while a request is outstanding
    a_r13_done_in_pend: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (s_q.st == ST_PEND));

    a_r8_write_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && op_q == OP_WRITE) |-> !ack_en_q);

    a_r6_cmd_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && op_q != OP_WRITE) |-> ack_en_q);

    a_r2_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> (!req_q && s_q.st == ST_IDLE && !s_q.bad));

    a_r14_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.bad && !flush_hit) |=> s_q.bad);

    a_r11_data_wr_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && s_q.st == ST_IDLE) |=> !req_q);

endmodule

// File: rtl/twi_host_ctrl.sv
module twi_host_ctrl
    import twi_hc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              smart_en,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic              eng_ack_en,
    output logic              eng_nack,
    output logic [DATA_W-1:0] eng_byte,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_done,
    output logic              flush_o
);

    localparam int STAT_BITS = 4;

    logic ctrl_wr, addr_wr, data_wr, data_rd;
    logic flush_hit, req_valid, req_nack, enter_wait;
    op_e  req_op, op_q;
    st_e  st_q;
    logic ack_q, dir_q, bad_q;
    logic [STAT_BITS-1:0] stat_bits;

    assign ctrl_wr = bus_wr && bus_addr == OFS_CTRL;
    assign addr_wr = bus_wr && bus_addr == OFS_ADDR;
    assign data_wr = bus_wr && bus_addr == OFS_DATA;
    assign data_rd = bus_rd && bus_addr == OFS_DATA;

    twi_hc_decode u_dec (
        .ctrl_wr   (ctrl_wr),
        .data_rd   (data_rd),
        .cmd       (bus_wdata[1:0]),
        .flush_bit (bus_wdata[BIT_FLUSH]),
        .ack_bit   (bus_wdata[BIT_ACK]),
        .smart_en  (smart_en),
        .ack_q     (ack_q),
        .dir_q     (dir_q),
        .idle      (st_q == ST_IDLE),
        .flush_hit (flush_hit),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_nack  (req_nack),
        .enter_wait(enter_wait)
    );

    twi_hc_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .addr_wr   (addr_wr),
        .data_wr   (data_wr),
        .ack_bit   (bus_wdata[BIT_ACK]),
        .wdata     (bus_wdata),
        .done      (eng_done),
        .flush_hit (flush_hit),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_nack  (req_nack),
        .enter_wait(enter_wait),
        .st_q      (st_q),
        .ack_q     (ack_q),
        .dir_q     (dir_q),
        .bad_q     (bad_q),
        .byte_q    (eng_byte),
        .req_q     (eng_req),
        .op_q      (op_q),
        .ack_en_q  (eng_ack_en),
        .nack_q    (eng_nack),
        .flush_q   (flush_o)
    );

    assign eng_op    = op_q;
    assign stat_bits = {bad_q, dir_q, st_q == ST_WAITD, st_q == ST_PEND};

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: bus_rdata[BIT_ACK] = ack_q;
            OFS_ADDR: bus_rdata[0]       = dir_q;
            OFS_DATA: bus_rdata          = eng_rx_data;
            default:  bus_rdata[STAT_BITS-1:0] = stat_bits;
        endcase
    end

endmodule

// File: tb/tb_twi_host_ctrl.sv
`timescale 1ns/1ps
module tb_twi_host_ctrl;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          smart_en = 1'b0;
    logic          eng_req, eng_ack_en, eng_nack, flush_o;
    logic [2:0]    eng_op;
    logic [DW-1:0] eng_byte;
    logic [DW-1:0] eng_rx_data = 8'h5E;
    logic          eng_done = 1'b0;

    int vecs = 0;
    int errs = 0;
    bit timed_out = 1'b0;

    always #10 clk = ~clk;

    twi_host_ctrl #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smart_en(smart_en), .eng_req(eng_req), .eng_op(eng_op),
        .eng_ack_en(eng_ack_en), .eng_nack(eng_nack), .eng_byte(eng_byte),
        .eng_rx_data(eng_rx_data), .eng_done(eng_done), .flush_o(flush_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic done_pulse();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic chk_req(input string tag, input logic [2:0] op, input logic aen, input logic nk);
        chk({tag, " req"}, eng_req, 1);
        chk({tag, " op"}, eng_op, op);
        chk({tag, " ack_en"}, eng_ack_en, aen);
        chk({tag, " nack"}, eng_nack, nk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1 req", eng_req, 0);
        chk("R1 flush", flush_o, 0);
        rd(2'd3, v); chk("R1 status", v, 0);
        rd(2'd0, v); chk("R1 ctrl", v, 0);
    endtask

    task automatic t_cmd0();
        wr(2'd0, 8'h00);
        chk("R5 no req", eng_req, 0);
    endtask

    task automatic t_rstart();
        wr(2'd1, 8'hA1);
        wr(2'd0, 8'h01);
        chk_req("R6", 3'd1, 1'b1, 1'b0);
        done_pulse();
    endtask

    task automatic t_same_write();
        logic [DW-1:0] v;
        wr(2'd0, 8'h05);
        chk_req("R12", 3'd1, 1'b1, 1'b1);
        done_pulse();
        rd(2'd0, v);
        chk("R3 ack readback", v, 8'h04);
        chk("R4 cmd reads zero", v[1:0], 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_read();
        wr(2'd1, 8'h41);
        wr(2'd0, 8'h06);
        chk_req("R7", 3'd2, 1'b1, 1'b1);
        done_pulse();
    endtask

    task automatic t_pending();
        logic [DW-1:0] v;
        wr(2'd0, 8'h03);
        chk_req("R9", 3'd4, 1'b1, 1'b0);
        rd(2'd3, v); chk("R13 pending bit", v[0], 1);
        wr(2'd0, 8'h01);
        chk("R13 ignored while pending", eng_req, 0);
        @(negedge clk);
        chk("R13 still no req", eng_req, 0);
        done_pulse();
        rd(2'd3, v); chk("R13 pending cleared", v[0], 0);
    endtask

    task automatic t_write();
        logic [DW-1:0] v;
        wr(2'd0, 8'h08);
        wr(2'd1, 8'hA0);
        wr(2'd0, 8'h02);
        chk("R8 no req yet", eng_req, 0);
        rd(2'd3, v); chk("R8 waiting bit", v[1], 1);
        wr(2'd2, 8'hA5);
        chk_req("R8", 3'd3, 1'b0, 1'b0);
        chk("R8 byte", eng_byte, 8'hA5);
        done_pulse();
    endtask

    task automatic t_data_no_ack();
        wr(2'd2, 8'h3C);
        chk("R11 data write no req", eng_req, 0);
        @(negedge clk);
        chk("R11 still none", eng_req, 0);
    endtask

    task automatic t_smart();
        logic [DW-1:0] v;
        smart_en = 1'b0;
        rd(2'd2, v);
        chk("R10 rx data", v, 8'h5E);
        chk("R10 no auto ack", eng_req, 0);
        wr(2'd0, 8'h04);
        smart_en = 1'b1;
        eng_rx_data = 8'hC3;
        rd(2'd2, v);
        chk("R10 rx data smart", v, 8'hC3);
        chk_req("R10", 3'd5, 1'b1, 1'b1);
        smart_en = 1'b0;
        done_pulse();
        wr(2'd0, 8'h00);
    endtask

    task automatic t_bad_seq();
        logic [DW-1:0] v;
        wr(2'd0, 8'h08);
        wr(2'd2, 8'h11);
        rd(2'd3, v); chk("R14 bad set", v[3], 1);
        wr(2'd1, 8'h51);
        rd(2'd3, v); chk("R14 bad sticky", v[3], 1);
        chk("R14 dir read", v[2], 1);
        wr(2'd1, 8'h50);
        rd(2'd3, v); chk("R14 dir write", v[2], 0);
        wr(2'd0, 8'h08);
        rd(2'd3, v); chk("R14 bad cleared by flush", v[3], 0);
    endtask

    task automatic t_flush();
        logic [DW-1:0] v;
        wr(2'd1, 8'h21);
        wr(2'd0, 8'h01);
        chk("R2 setup req", eng_req, 1);
        wr(2'd0, 8'h08);
        chk("R2 flush pulse", flush_o, 1);
        chk("R2 no req on flush", eng_req, 0);
        @(negedge clk);
        chk("R2 pulse one cycle", flush_o, 0);
        rd(2'd3, v); chk("R2 status cleared", v, 0);
        wr(2'd0, 8'h09);
        chk("R2 flush with cmd", flush_o, 1);
        chk("R2 cmd discarded", eng_req, 0);
        wr(2'd1, 8'h21);
        wr(2'd0, 8'h00);
        chk("R2 zero no pulse", flush_o, 0);
        rd(2'd3, v); chk("R2 zero keeps status", v, 8'h04);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd0();
        t_rstart();
        t_same_write();
        t_read();
        t_pending();
        t_write();
        t_data_no_ack();
        t_smart();
        t_bad_seq();
        t_flush();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            errs++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule